// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A small synchronous static memory with a 36-bit word. The word is split into four lanes of nine bits each: eight data bits and one parity bit per lane. The address, the write data, the three chip enables, the write controls and the burst controls are all captured on the rising clock edge. Each access is therefore decided by the values present at one edge. Two address strobes can open a burst of up to four beats. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write, or it deselects the chip. While neither strobe is active, the advance input either steps the burst to its next address or holds it on the current address. Two orders of the low address bits are available: linear and interleaved.

Read data leaves registers in the cycle after the edge that set its address, so a four-beat read follows a 2-1-1-1 cadence. The data bus is modelled as separate input, output and output-enable ports. The enable is gated asynchronously by the active-low output enable and by the sleep input. A high level on sleep blocks every access and turns the bus off at once.

Top module: `burst_sram_core`

## Requirements
- R1: The chip counts as selected only when `ce_lo_n`=0, `ce_hi`=1 and `ce2_lo_n`=0. A strobe edge taken while any of the three disagrees performs no access. It also ends any open burst, so `dout_en` stays 0 after that edge and after later advance cycles.
- R2: The processor strobe is active when `cpu_strobe_n`=0 and `ce_lo_n`=0. If the chip is selected, it begins a read burst at `addr` whatever the write controls are. It takes priority over the controller strobe. With `ce_lo_n`=1 the processor strobe starts nothing.
- R3: The controller strobe is `ctl_strobe_n`=0 while the processor strobe is inactive. When the chip is selected, it captures `addr` and begins a write if a write request is present at the same edge, and a read otherwise.
- R4: A write request exists when `glob_wr_n`=0, or when `byte_wr_n`=0 with at least one `lane_wr_n` bit at 0. With `glob_wr_n`=0 all four lanes are written, whatever the other write inputs are. The `lane_wr_n` bits count only while `byte_wr_n`=0.
- R5: Lane k (k=0..3) holds bus bits [8k+7:8k] plus parity bit 32+k. `lane_wr_n[k]` is the enable of lane k. Lanes that are not enabled keep their contents.
- R6: Data for a read at edge N is on `dout` in the cycle after edge N. `dout_en`=1 in that cycle when `oe_n`=0 and `sleep`=0.
- R7: With no active strobe and an open burst, `adv_n`=0 steps to the next burst address. That cycle reads, or writes if a write request is present. This is how a write follows a processor strobe.
- R8: With no active strobe and an open burst, `adv_n`=1 repeats the access at the current burst address.
- R9: The upper address bits stay fixed for the whole burst. Beat k uses low two bits (base+k) mod 4 when `lin_mode`=1, and base XOR k when `lin_mode`=0.
- R10: `dout_en` follows `oe_n` with no clock edge and is 0 while `oe_n`=1. After a write edge, `dout_en` is 0 whatever `oe_n` is.
- R11: While `sleep`=1 no access or write happens, `dout_en` drops at once, and any open burst ends.
- R12: After reset `dout_en`=0 and no burst is open, so advance cycles before the first strobe perform no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address captured by a strobe |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low, read only |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, low steps and high holds |
| ce_lo_n | input | 1 | Primary chip enable, active low, also gates the processor strobe |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce2_lo_n | input | 1 | Secondary chip enable, active low |
| glob_wr_n | input | 1 | Write all lanes, active low |
| byte_wr_n | input | 1 | Enables the per-lane write inputs, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Standby request, active high |
| din | input | LANES*(LANE_DW+1) | Write data, with data lanes low and parity bits high |
| dout | output | LANES*(LANE_DW+1) | Registered read data |
| dout_en | output | 1 | Bus drive enable for dout |

## Verification
The embedded properties check the following on every cycle:
- The processor strobe never produces a write.
- A deselecting strobe closes the burst.
- A suspend holds the beat count and an advance raises it by one.
- Sleep blocks all lane writes.
- A write edge is never followed by a driven bus.
- A global write enables all lanes.

Other behaviours can only be shown by the scoreboard scenarios, which compare against a reference array:
- The actual data returned in each burst order.
- Partial lane merges and the parity bit placement.
- The asynchronous response of `dout_en` to `oe_n` and `sleep` between clock edges.
- That writes attempted while asleep leave the memory unchanged.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             glob_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] wr_mask,
  output logic             wr_req
);
  // global write wins; lane enables are qualified by the byte-write gate
  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign wr_mask[k] = !glob_wr_n || (!byte_wr_n && !lane_wr_n[k]);
  end
  assign wr_req = |wr_mask;
endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
  import sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep,
  input  logic          cpu_strobe_n,
  input  logic          ctl_strobe_n,
  input  logic          adv_n,
  input  logic          ce_lo_n,
  input  logic          ce_hi,
  input  logic          ce2_lo_n,
  input  logic          lin_mode,
  input  logic [AW-1:0] addr,
  input  logic          wr_req,
  output acc_kind_e     acc,
  output logic [AW-1:0] acc_addr
);
  localparam logic [BB-1:0] ONE = {{(BB-1){1'b0}}, 1'b1};

  logic          active_q;
  logic [AW-1:0] base_q;
  logic [BB-1:0] cnt_q;

  logic          sel, cpu_hit, ctl_hit, strobe;
  logic          start, cont;
  logic [AW-1:0] nxt_base;
  logic [BB-1:0] nxt_cnt, low;
  logic          nxt_active;

  assign sel     = !ce_lo_n && ce_hi && !ce2_lo_n;
  assign cpu_hit = !cpu_strobe_n && !ce_lo_n;
  assign ctl_hit = !ctl_strobe_n && !cpu_hit;
  assign strobe  = cpu_hit || ctl_hit;

  always_comb begin
    start = 1'b0;
    cont  = 1'b0;
    if (!sleep) begin
      if (strobe) start = sel;
      else        cont  = active_q;
    end
  end

  always_comb begin
    acc = ACC_IDLE;
    if (start)     acc = (cpu_hit || !wr_req) ? ACC_RD : ACC_WR;
    else if (cont) acc = wr_req ? ACC_WR : ACC_RD;
  end

  always_comb begin
    nxt_base = start ? addr : base_q;
    if (start)              nxt_cnt = '0;
    else if (cont && !adv_n) nxt_cnt = cnt_q + ONE;
    else                    nxt_cnt = cnt_q;
    if (sleep)       nxt_active = 1'b0;
    else if (strobe) nxt_active = sel;
    else             nxt_active = active_q;
  end

  assign low      = lin_mode ? (nxt_base[BB-1:0] + nxt_cnt) : (nxt_base[BB-1:0] ^ nxt_cnt);
  assign acc_addr = {nxt_base[AW-1:BB], low};

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= nxt_active;
      base_q   <= nxt_base;
      cnt_q    <= nxt_cnt;
    end
  end

  // R2: processor strobe with selection is always a read
  a_r2_cpu_reads: assert property (@(posedge clk) disable iff (rst)
    (!sleep && cpu_hit && sel) |-> (acc == ACC_RD));
  // R1: a deselecting strobe closes the burst
  a_r1_deselect_closes: assert property (@(posedge clk) disable iff (rst)
    (!sleep && strobe && !sel) |=> !active_q);
  // R8: suspend keeps the beat count
  a_r8_suspend_holds: assert property (@(posedge clk) disable iff (rst)
    (cont && adv_n) |=> (cnt_q == $past(cnt_q)));
  // R7: advance steps the beat count by one
  a_r7_advance_steps: assert property (@(posedge clk) disable iff (rst)
    (cont && !adv_n) |=> (cnt_q == $past(cnt_q) + ONE));
  // R11: sleep blocks all accesses
  a_r11_sleep_idle: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (acc == ACC_IDLE));
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int AW = 6,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] a,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  q
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= wd;
    if (re) q <= mem[a];
  end
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_DW = 8,
  parameter int BURST_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         cpu_strobe_n,
  input  logic                         ctl_strobe_n,
  input  logic                         adv_n,
  input  logic                         ce_lo_n,
  input  logic                         ce_hi,
  input  logic                         ce2_lo_n,
  input  logic                         glob_wr_n,
  input  logic                         byte_wr_n,
  input  logic [LANES-1:0]             lane_wr_n,
  input  logic                         oe_n,
  input  logic                         lin_mode,
  input  logic                         sleep,
  input  logic [LANES*(LANE_DW+1)-1:0] din,
  output logic [LANES*(LANE_DW+1)-1:0] dout,
  output logic                         dout_en
);
  localparam int LW     = LANE_DW + 1;
  localparam int PAR_LO = LANES * LANE_DW;

  logic [LANES-1:0]  wr_mask, lane_we;
  logic              wr_req;
  acc_kind_e         acc;
  logic [ADDR_W-1:0] acc_addr;
  logic              rd_valid;
  logic              rd_go;

  sram_wr_decode #(.LANES(LANES)) u_wdec (
    .glob_wr_n (glob_wr_n),
    .byte_wr_n (byte_wr_n),
    .lane_wr_n (lane_wr_n),
    .wr_mask   (wr_mask),
    .wr_req    (wr_req)
  );

  sram_burst_ctrl #(.AW(ADDR_W), .BB(BURST_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sleep        (sleep),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .adv_n        (adv_n),
    .ce_lo_n      (ce_lo_n),
    .ce_hi        (ce_hi),
    .ce2_lo_n     (ce2_lo_n),
    .lin_mode     (lin_mode),
    .addr         (addr),
    .wr_req       (wr_req),
    .acc          (acc),
    .acc_addr     (acc_addr)
  );

  assign rd_go   = (acc == ACC_RD);
  assign lane_we = (acc == ACC_WR) ? wr_mask : '0;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LW-1:0] wd, q;
    assign wd = {din[PAR_LO + k], din[k*LANE_DW +: LANE_DW]};
    sram_lane #(.AW(ADDR_W), .W(LW)) u_lane (
      .clk (clk),
      .we  (lane_we[k]),
      .re  (rd_go),
      .a   (acc_addr),
      .wd  (wd),
      .q   (q)
    );
    assign dout[k*LANE_DW +: LANE_DW] = q[LANE_DW-1:0];
    assign dout[PAR_LO + k]           = q[LANE_DW];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_go;
  end

  assign dout_en = rd_valid && !oe_n && !sleep;

  // R10: nothing is driven after a write edge
  a_r10_quiet_after_write: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_WR) |=> !dout_en);
  // R6: a read edge is followed by a drive gated only by oe_n and sleep
  a_r6_read_then_drive: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_RD) |=> (dout_en == (!oe_n && !sleep)));
  // R4: global write reaches every lane
  a_r4_global_all_lanes: assert property (@(posedge clk) disable iff (rst)
    ((acc == ACC_WR) && !glob_wr_n) |-> (&lane_we));
  // R11: no lane write while asleep
  a_r11_sleep_no_write: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (lane_we == '0));
endmodule

// File: tb/sim_burst_sram_core.sv
`timescale 1ns/1ps
module sim_burst_sram_core;
  localparam int AW = 6;
  localparam int BW = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [AW-1:0] addr;
  logic cpu_strobe_n, ctl_strobe_n, adv_n, ce_lo_n, ce_hi, ce2_lo_n;
  logic glob_wr_n, byte_wr_n, oe_n, lin_mode, sleep;
  logic [3:0] lane_wr_n;
  logic [BW-1:0] din, dout;
  logic dout_en;

  burst_sram_core u0 (
    .clk(clk), .rst(rst), .addr(addr), .cpu_strobe_n(cpu_strobe_n),
    .ctl_strobe_n(ctl_strobe_n), .adv_n(adv_n), .ce_lo_n(ce_lo_n),
    .ce_hi(ce_hi), .ce2_lo_n(ce2_lo_n), .glob_wr_n(glob_wr_n),
    .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
    .lin_mode(lin_mode), .sleep(sleep), .din(din), .dout(dout),
    .dout_en(dout_en)
  );

  typedef struct {
    bit            chk;
    bit            en;
    logic [BW-1:0] d;
    string         tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // staged stimulus, applied at the next falling edge
  logic s_cpu, s_ctl, s_adv, s_celo, s_cehi, s_ce2, s_glob, s_bwe, s_oe, s_slp, s_lin;
  logic [3:0] s_lanes;
  logic [AW-1:0] s_addr;
  logic [BW-1:0] s_din;

  // reference model
  logic [BW-1:0] ref_mem [64];
  bit m_act = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_cnt = '0;

  function automatic logic [BW-1:0] pat(int a);
    logic [7:0] b;
    b = 8'(a);
    return {4'(b[3:0] ^ 4'h9), b ^ 8'h5A, 8'(b * 3 + 1), ~b, b + 8'h40};
  endfunction

  task automatic check(bit ok, string tag, logic [BW-1:0] act, logic [BW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic idle();
    s_cpu = 1; s_ctl = 1; s_adv = 1; s_celo = 0; s_cehi = 1; s_ce2 = 0;
    s_glob = 1; s_bwe = 1; s_lanes = 4'hF; s_oe = 0; s_slp = 0;
    s_addr = '0; s_din = '0;
  endtask

  task automatic cyc(string tag, bit chk = 1);
    bit sel, acc, wr;
    logic [3:0] mask;
    logic [1:0] lo;
    logic [AW-1:0] ea;
    exp_t it;
    @(negedge clk);
    cpu_strobe_n = s_cpu; ctl_strobe_n = s_ctl; adv_n = s_adv;
    ce_lo_n = s_celo; ce_hi = s_cehi; ce2_lo_n = s_ce2;
    glob_wr_n = s_glob; byte_wr_n = s_bwe; lane_wr_n = s_lanes;
    oe_n = s_oe; sleep = s_slp; addr = s_addr; din = s_din; lin_mode = s_lin;
    sel  = !s_celo && s_cehi && !s_ce2;
    for (int k = 0; k < 4; k++) mask[k] = !s_glob || (!s_bwe && !s_lanes[k]);
    acc = 0; wr = 0;
    if (s_slp) m_act = 0;
    else if (!s_cpu && !s_celo) begin
      m_act = sel;
      if (sel) begin m_base = s_addr; m_cnt = 0; acc = 1; wr = 0; end
    end else if (!s_ctl) begin
      m_act = sel;
      if (sel) begin m_base = s_addr; m_cnt = 0; acc = 1; wr = |mask; end
    end else if (m_act) begin
      if (!s_adv) m_cnt = m_cnt + 2'd1;
      acc = 1; wr = |mask;
    end
    lo = s_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
    ea = {m_base[AW-1:2], lo};
    if (acc && wr)
      for (int k = 0; k < 4; k++)
        if (mask[k]) begin
          ref_mem[ea][k*8 +: 8] = s_din[k*8 +: 8];
          ref_mem[ea][32+k]     = s_din[32+k];
        end
    it.chk = chk;
    it.en  = acc && !wr && !s_oe && !s_slp;
    it.d   = ref_mem[ea];
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares each cycle's output against the queued expectation
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.chk) begin
          check(dout_en === it.en, {it.tag, " dout_en"}, {35'd0, dout_en}, {35'd0, it.en});
          if (it.en) check(dout === it.d, {it.tag, " data"}, dout, it.d);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    s_lin = 1;
    idle();
    cpu_strobe_n = 1; ctl_strobe_n = 1; adv_n = 1; ce_lo_n = 0; ce_hi = 1; ce2_lo_n = 0;
    glob_wr_n = 1; byte_wr_n = 1; lane_wr_n = 4'hF; oe_n = 0; lin_mode = 1;
    sleep = 0; addr = '0; din = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check(dout_en === 1'b0, "R12 reset dout_en", {35'd0, dout_en}, '0);
    // R12: advance before any strobe does nothing
    idle(); s_adv = 0; cyc("R12 advance after reset");

    // R3 R4: fill through controller strobe with global write
    for (int a = 0; a < 64; a++) begin
      idle(); s_ctl = 0; s_glob = 0; s_addr = AW'(a); s_din = pat(a);
      cyc("R3 fill write");
    end
    // R3 R6: single reads
    idle(); s_ctl = 0; s_addr = 6'd5;  cyc("R3 R6 single read 5");
    idle(); s_ctl = 0; s_addr = 6'd40; cyc("R3 R6 single read 40");

    // R7 R9: linear burst from 14 -> 15,12,13
    idle(); s_cpu = 0; s_addr = 6'd14; cyc("R2 R6 burst start");
    repeat (3) begin idle(); s_adv = 0; cyc("R7 R9 linear advance"); end
    // R8: suspend repeats 13
    repeat (2) begin idle(); cyc("R8 suspend"); end
    idle(); s_adv = 0; cyc("R7 advance after suspend");

    // R9: interleaved burst from 45 -> 44,47,46
    s_lin = 0;
    idle(); s_cpu = 0; s_addr = 6'd45; cyc("R9 interleaved start");
    repeat (3) begin idle(); s_adv = 0; cyc("R9 interleaved advance"); end
    s_lin = 1;

    // R2: processor strobe ignores write controls
    idle(); s_cpu = 0; s_glob = 0; s_addr = 6'd20; s_din = '1; cyc("R2 cpu strobe reads");
    // R7 R4 R5: write lane 0 on the following hold cycle
    idle(); s_bwe = 0; s_lanes = 4'b1110; s_din = 36'hA_1234_5678; cyc("R7 R5 lane0 write");
    idle(); s_ctl = 0; s_addr = 6'd20; cyc("R5 readback lane0");

    // R4 R5: lanes 1 and 3
    idle(); s_ctl = 0; s_bwe = 0; s_lanes = 4'b0101; s_addr = 6'd30; s_din = 36'h5_CAFE_BEEF;
    cyc("R4 R5 lanes1,3 write");
    idle(); s_ctl = 0; s_addr = 6'd30; cyc("R5 readback lanes1,3");
    // R4: lane enables without byte-write gate are a read
    idle(); s_ctl = 0; s_bwe = 1; s_lanes = 4'h0; s_addr = 6'd31; s_din = '1; cyc("R4 gate high reads");
    // R4: global overrides lane enables
    idle(); s_ctl = 0; s_glob = 0; s_bwe = 1; s_lanes = 4'hF; s_addr = 6'd32; s_din = 36'h3_0F0F_F0F0;
    cyc("R4 global write");
    idle(); s_ctl = 0; s_addr = 6'd32; cyc("R4 readback global");

    // R1: each enable fault deselects and ends the burst
    idle(); s_ctl = 0; s_addr = 6'd5; s_celo = 1; cyc("R1 ce_lo_n high");
    idle(); s_adv = 0; cyc("R1 no burst after deselect");
    idle(); s_ctl = 0; s_addr = 6'd5; s_cehi = 0; cyc("R1 ce_hi low");
    idle(); s_ctl = 0; s_addr = 6'd5; s_ce2 = 1; cyc("R1 ce2_lo_n high");
    idle(); s_cpu = 0; s_addr = 6'd6; cyc("R2 R6 read before fault");
    idle(); s_cpu = 0; s_addr = 6'd6; s_ce2 = 1; cyc("R1 cpu strobe deselect");
    idle(); s_adv = 0; cyc("R1 burst ended");
    // R2: processor strobe gated off by ce_lo_n
    idle(); s_cpu = 0; s_celo = 1; s_addr = 6'd7; cyc("R2 gated cpu strobe");

    // R10: oe_n high blocks drive; asynchronous toggle
    idle(); s_ctl = 0; s_addr = 6'd6; s_oe = 1; cyc("R10 oe high");
    idle(); s_ctl = 0; s_addr = 6'd7; cyc("R10 read 7");
    @(posedge clk); #7;
    check(dout_en === 1'b1, "R10 before toggle", {35'd0, dout_en}, 36'd1);
    oe_n = 1; #1;
    check(dout_en === 1'b0, "R10 async oe off", {35'd0, dout_en}, 36'd0);
    oe_n = 0; #1;
    check(dout_en === 1'b1, "R10 async oe on", {35'd0, dout_en}, 36'd1);

    // R11: sleep
    idle(); s_ctl = 0; s_addr = 6'd8; cyc("R11 read before sleep");
    @(posedge clk); #7;
    sleep = 1; #1;
    check(dout_en === 1'b0, "R11 async sleep", {35'd0, dout_en}, 36'd0);
    sleep = 0; #1;
    idle(); s_slp = 1; s_adv = 0; cyc("R11 sleep advance");
    idle(); s_slp = 1; s_ctl = 0; s_glob = 0; s_addr = 6'd9; s_din = '0; cyc("R11 sleep write");
    idle(); s_adv = 0; cyc("R11 burst ended by sleep");
    idle(); s_ctl = 0; s_addr = 6'd9; cyc("R11 memory kept");

    idle(); cyc("flush", 0);
    idle(); cyc("flush", 0);
    @(posedge clk); #8;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule